// File: doc/BRIEF.md
# Nibble ALU with Decimal Adjust

This block is the arithmetic and logic stage of a processor whose datapath is four bits wide. Each cycle it takes two nibble operands, an operation code, the carry flag currently held by the processor, the processor's decimal-mode flag and a per-instruction qualifier that allows decimal adjustment. It returns a nibble result, new values for the carry and zero flags, and one write enable for each flag. The processor keeps the flags itself and updates only the flags whose enable is high. Logic operations therefore keep the stored carry.

The supported operations are:
- plain add and subtract, and add and subtract with the incoming carry;
- AND, OR and XOR;
- increment and decrement;
- rotate left and rotate right through the carry.

When decimal mode and the qualifier are both set, the add and subtract family corrects its result to packed-BCD. The correction is decided from the wide intermediate result. Nibble half-carry logic is not used. The outputs are registered once, so a result appears one clock after its operands.

Top module: `nib_alu`

## Requirements
- R1: Operation code 0 (add) gives result (a+b) mod 16. Code 1 (add with carry) gives (a+b+cin) mod 16. In both, carry is bit 4 of the 5-bit sum.
- R2: Operation code 2 (subtract) gives (a-b) mod 16. Code 3 (subtract with carry) gives (a-(b+cin)) mod 16. In both, carry is 1 exactly when the difference is negative (borrow).
- R3: For codes 0 and 1 with decimal correction active, if the binary sum is 10 or more, the result is (sum-10) mod 16 and carry is forced to 1. Otherwise the result and carry are those of R1.
- R4: For codes 2 and 3 with decimal correction active, if a borrow occurred, a further 6 is subtracted from the difference (mod 16). Carry stays equal to the borrow.
- R5: Decimal correction is active only when both the decimal-mode input and the qualifier input are 1. With either one at 0, codes 0 to 3 behave as in R1 and R2.
- R6: Codes 4, 5 and 6 (AND, OR, XOR) give the bitwise result. Carry-enable is 0, carry output equals cin, and zero-enable is 1.
- R7: Code 7 (increment) gives (a+1) mod 16, with carry 1 only for a=15. Code 8 (decrement) gives (a-1) mod 16, with carry 1 only for a=0. Decimal correction never applies to either.
- R8: Code 9 (rotate left through carry) gives result {a[2:0],cin} and carry a[3].
- R9: Code 10 (rotate right through carry) gives result {cin,a[3:1]} and carry a[0].
- R10: For codes 0 to 10, zero is 1 exactly when the 4-bit result is 0, and zero-enable is 1. Carry-enable is 1 for every code except 4, 5 and 6.
- R11: Codes 11 to 15 are unused. The result equals a, carry equals cin, zero reflects that result, and both enables are 0.
- R12: All outputs are registered and appear on the clock edge after the inputs are applied. While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Operation code (see requirements) |
| a_i | input | 4 | First operand, also the rotate/increment source |
| b_i | input | 4 | Second operand |
| cin_i | input | 1 | Current stored carry flag |
| dmode_i | input | 1 | Processor decimal-mode flag |
| dqual_i | input | 1 | Instruction allows decimal correction |
| res_o | output | 4 | Result nibble |
| cout_o | output | 1 | Next carry flag value |
| zout_o | output | 1 | Next zero flag value |
| cwe_o | output | 1 | Carry flag update enable |
| zwe_o | output | 1 | Zero flag update enable |

## Verification
The in-design assertions check every cycle that:
- logic and unused codes drive the flag enables correctly;
- both rotates move the right bits into and out of the carry;
- increment and decrement produce carry only at the wrap values;
- a corrected decimal add sets carry exactly when the binary sum reaches ten.

The exact result values need the bench's reference model across all operand, carry and mode combinations. These include the extra subtract-6 after a decimal borrow, and the fact that decimal correction stays off when only one of mode and qualifier is set. The reset values also rely on the bench.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;
    localparam int NIB_W  = 4;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_INC = 4'd7,
        OP_DEC = 4'd8,
        OP_RLC = 4'd9,
        OP_RRC = 4'd10
    } alu_op_e;

    typedef struct packed {
        logic [NIB_W-1:0] res;
        logic             c;
        logic             z;
        logic             c_we;
        logic             z_we;
    } alu_out_t;
endpackage

// File: rtl/nib_alu_arith.sv
module nib_alu_arith
    import nib_alu_pkg::*;
#(
    parameter int W = NIB_W
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic            cin,
    input  logic            dec_on,
    output logic [W-1:0]    res,
    output logic            cout
);
    localparam logic [W:0] DEC_LIMIT = (W+1)'(10);
    localparam logic [W:0] DEC_SUBADJ = (W+1)'(6);

    logic [W:0] addend;
    logic [W:0] wide;
    logic       cy;

    always_comb begin
        addend = {1'b0, b};
        if (op == OP_ADC || op == OP_SBC) begin
            addend = addend + {{W{1'b0}}, cin};
        end
        wide = '0;
        cy   = 1'b0;
        case (op)
            OP_ADD, OP_ADC: begin
                wide = {1'b0, a} + addend;
                cy   = wide[W];
                if (dec_on && wide >= DEC_LIMIT) begin
                    wide = wide - DEC_LIMIT;
                    cy   = 1'b1;
                end
            end
            OP_SUB, OP_SBC: begin
                wide = {1'b0, a} - addend;
                cy   = wide[W];
                if (dec_on && cy) begin
                    wide = wide - DEC_SUBADJ;
                end
            end
            OP_INC: begin
                wide = {1'b0, a} + (W+1)'(1);
                cy   = wide[W];
            end
            OP_DEC: begin
                wide = {1'b0, a} - (W+1)'(1);
                cy   = wide[W];
            end
            default: begin
                wide = {1'b0, a};
                cy   = 1'b0;
            end
        endcase
        res  = wide[W-1:0];
        cout = cy;
    end
endmodule

// File: rtl/nib_alu_logic.sv
module nib_alu_logic
    import nib_alu_pkg::*;
#(
    parameter int W = NIB_W
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output logic [W-1:0]    res
);
    always_comb begin
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            default: res = a;
        endcase
    end
endmodule

// File: rtl/nib_alu_rotate.sv
module nib_alu_rotate #(
    parameter int W = nib_alu_pkg::NIB_W
) (
    input  logic         to_right,
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    always_comb begin
        if (to_right) begin
            res  = {cin, a[W-1:1]};
            cout = a[0];
        end else begin
            res  = {a[W-2:0], cin};
            cout = a[W-1];
        end
    end
endmodule

// File: rtl/nib_alu.sv
module nib_alu
    import nib_alu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OP_W-1:0]  op_i,
    input  logic [NIB_W-1:0] a_i,
    input  logic [NIB_W-1:0] b_i,
    input  logic             cin_i,
    input  logic             dmode_i,
    input  logic             dqual_i,
    output logic [NIB_W-1:0] res_o,
    output logic             cout_o,
    output logic             zout_o,
    output logic             cwe_o,
    output logic             zwe_o
);
    logic [NIB_W-1:0] ar_res, lg_res, rt_res;
    logic             ar_c, rt_c;
    alu_out_t         out_d, out_q;
    logic             seen_d, seen_q;

    nib_alu_arith #(.W(NIB_W)) u_arith (
        .op(op_i), .a(a_i), .b(b_i), .cin(cin_i),
        .dec_on(dmode_i & dqual_i), .res(ar_res), .cout(ar_c)
    );

    nib_alu_logic #(.W(NIB_W)) u_logic (
        .op(op_i), .a(a_i), .b(b_i), .res(lg_res)
    );

    nib_alu_rotate #(.W(NIB_W)) u_rot (
        .to_right(op_i == OP_RRC), .a(a_i), .cin(cin_i),
        .res(rt_res), .cout(rt_c)
    );

    always_comb begin
        out_d      = '0;
        out_d.res  = a_i;
        out_d.c    = cin_i;
        out_d.c_we = 1'b0;
        out_d.z_we = 1'b0;
        case (op_i)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_INC, OP_DEC: begin
                out_d.res  = ar_res;
                out_d.c    = ar_c;
                out_d.c_we = 1'b1;
                out_d.z_we = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR: begin
                out_d.res  = lg_res;
                out_d.z_we = 1'b1;
            end
            OP_RLC, OP_RRC: begin
                out_d.res  = rt_res;
                out_d.c    = rt_c;
                out_d.c_we = 1'b1;
                out_d.z_we = 1'b1;
            end
            default: ;
        endcase
        out_d.z = (out_d.res == '0);
        seen_d  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            out_q  <= out_d;
            seen_q <= seen_d;
        end
    end

    assign res_o  = out_q.res;
    assign cout_o = out_q.c;
    assign zout_o = out_q.z;
    assign cwe_o  = out_q.c_we;
    assign zwe_o  = out_q.z_we;

    // R6
    logic_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && ($past(op_i) inside {OP_AND, OP_OR, OP_XOR}))
        |-> (!cwe_o && zwe_o && cout_o == $past(cin_i)));

    // R11
    unused_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(op_i) > OP_RRC) |-> (!cwe_o && !zwe_o && res_o == $past(a_i)));

    // R8
    rotl_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(op_i) == OP_RLC)
        |-> (cout_o == $past(a_i[NIB_W-1]) && res_o[0] == $past(cin_i)));

    // R9
    rotr_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(op_i) == OP_RRC)
        |-> (cout_o == $past(a_i[0]) && res_o[NIB_W-1] == $past(cin_i)));

    // R7
    inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(op_i) == OP_INC) |-> (cout_o == ($past(a_i) == '1)));

    // R7
    dec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(op_i) == OP_DEC) |-> (cout_o == ($past(a_i) == '0)));

    // R3
    dec_add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(op_i) == OP_ADD && $past(dmode_i) && $past(dqual_i))
        |-> (cout_o == (({1'b0, $past(a_i)} + {1'b0, $past(b_i)}) >= 5'd10)));
endmodule

// File: tb/test_nib_alu.sv
module test_nib_alu;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = '0, a_i = '0, b_i = '0;
    logic       cin_i = 1'b0, dmode_i = 1'b0, dqual_i = 1'b0;
    logic [3:0] res_o;
    logic       cout_o, zout_o, cwe_o, zwe_o;

    int applied = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0] res;
        logic       c, z, cwe, zwe;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    nib_alu i_nib_alu (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .cin_i(cin_i), .dmode_i(dmode_i), .dqual_i(dqual_i),
        .res_o(res_o), .cout_o(cout_o), .zout_o(zout_o),
        .cwe_o(cwe_o), .zwe_o(zwe_o)
    );

    function automatic exp_t model(int op, int a, int b, int c, int dm, int dq);
        exp_t e;
        int r, co, cwe, zwe, s, dec;
        dec = dm & dq;
        r = a; co = c; cwe = 1; zwe = 1;
        e.tag = "R11";
        case (op)
            0, 1: begin
                s = a + b + ((op == 1) ? c : 0);
                r = s % 16; co = (s >= 16) ? 1 : 0;
                e.tag = (dm != dq) ? "R5" : "R1";
                if (dec == 1) begin
                    e.tag = "R3";
                    if (s >= 10) begin r = (s - 10) % 16; co = 1; end
                end
            end
            2, 3: begin
                s = a - (b + ((op == 3) ? c : 0));
                co = (s < 0) ? 1 : 0;
                r = s & 15;
                e.tag = (dm != dq) ? "R5" : "R2";
                if (dec == 1) begin
                    e.tag = "R4";
                    if (co == 1) r = (s - 6) & 15;
                end
            end
            4: begin r = a & b; cwe = 0; e.tag = "R6"; end
            5: begin r = a | b; cwe = 0; e.tag = "R6"; end
            6: begin r = a ^ b; cwe = 0; e.tag = "R6"; end
            7: begin r = (a + 1) & 15; co = (a == 15) ? 1 : 0; e.tag = "R7"; end
            8: begin r = (a - 1) & 15; co = (a == 0) ? 1 : 0; e.tag = "R7"; end
            9: begin r = ((a * 2) + c) & 15; co = (a >= 8) ? 1 : 0; e.tag = "R8"; end
            10: begin r = (a / 2) + (c * 8); co = a % 2; e.tag = "R9"; end
            default: begin r = a; co = c; cwe = 0; zwe = 0; end
        endcase
        e.res = 4'(r);
        e.c   = co[0];
        e.z   = (r == 0);
        e.cwe = cwe[0];
        e.zwe = zwe[0];
        return e;
    endfunction

    task automatic apply(int op, int a, int b, int c, int dm, int dq);
        exp_t e;
        @(negedge clk);
        op_i = 4'(op); a_i = 4'(a); b_i = 4'(b);
        cin_i = c[0]; dmode_i = dm[0]; dqual_i = dq[0];
        e = model(op, a, b, c, dm, dq);
        sb.push_back(e);
    endtask

    task automatic directed(int op, int a, int b, int c, int dm, int dq,
                            int er, int ec, string tag);
        exp_t e;
        apply(op, a, b, c, dm, dq);
        e = sb[sb.size()-1];
        if (e.res != 4'(er) || e.c != ec[0]) begin
            $display("model inconsistency %s", tag);
        end
        sb[sb.size()-1].tag = tag;
    endtask

    // monitor: compares one registered result per cycle
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            if (rst_n && sb.size() > 0) begin
                e = sb.pop_front();
                #2;
                applied++;
                if (res_o !== e.res || cout_o !== e.c || zout_o !== e.z ||
                    cwe_o !== e.cwe || zwe_o !== e.zwe) begin
                    bad++;
                    $display("FAIL %s: got res=%h c=%b z=%b cwe=%b zwe=%b exp res=%h c=%b z=%b cwe=%b zwe=%b",
                             e.tag, res_o, cout_o, zout_o, cwe_o, zwe_o,
                             e.res, e.c, e.z, e.cwe, e.zwe);
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog: got hang exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
            $finish;
        end
    end

    initial begin
        op_i = 4'd7; a_i = 4'hF;
        repeat (3) @(posedge clk);
        #2;
        applied++;
        if ({res_o, cout_o, zout_o, cwe_o, zwe_o} !== 8'h00) begin
            bad++;
            $display("FAIL R12: got %h exp 00 during reset",
                     {res_o, cout_o, zout_o, cwe_o, zwe_o});
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R3 decimal add corner cases
        directed(0, 9, 9, 0, 1, 1, 8, 1, "R3");
        directed(0, 5, 5, 0, 1, 1, 0, 1, "R3");
        directed(1, 4, 4, 1, 1, 1, 9, 0, "R3");
        // R4 decimal subtract: 3-5 -> 8 with borrow
        directed(2, 3, 5, 0, 1, 1, 8, 1, "R4");
        // R5 mode without qualifier: plain binary
        directed(0, 9, 9, 0, 1, 0, 2, 1, "R5");
        // R2 borrow on subtract-with-carry from zero
        directed(3, 0, 15, 1, 0, 0, 0, 1, "R2");
        // R10 zero flag after logic result 0
        directed(4, 10, 5, 1, 0, 0, 0, 1, "R10");
        // R7 wrap values
        directed(7, 15, 0, 0, 1, 1, 0, 1, "R7");
        directed(8, 0, 0, 0, 1, 1, 15, 1, "R7");
        // R8/R9 rotates
        directed(9, 8, 0, 1, 0, 0, 1, 1, "R8");
        directed(10, 1, 0, 1, 0, 0, 8, 1, "R9");
        // R11 unused code
        directed(13, 6, 3, 1, 1, 1, 6, 1, "R11");

        // sweep every code, operand, carry and decimal combination
        for (int op = 0; op < 16; op++)
            for (int m = 0; m < 8; m++)
                for (int a = 0; a < 16; a++)
                    for (int b = 0; b < 16; b++)
                        apply(op, a, b, m & 1, (m >> 1) & 1, (m >> 2) & 1);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end
endmodule